// File: doc/BRIEF.md
# Board Reset Sequencer with Cause Capture

This block turns several board-level reset requests into the reset outputs of a processor core. The inputs are a good flag for each supply rail, a configuration-complete flag, and two front-panel buttons. One button requests a full power-on reset. The other requests an externally initiated reset (XIR). The outputs are an active-low system reset, a separate single-cycle XIR pulse, and a two-bit cause register. Software reads the cause register and clears it by writing ones.

The system reset is asserted while any rail reports a fault or while configuration is incomplete. An accepted power-on button press also asserts it. The reset is released only after a fixed hold stretch in which every release condition has stayed true. Both button inputs are synchronized to the clock and debounced against a sample tick made inside the block. The rail and configuration flags are taken as digital levels that are already synchronous to the clock. Resets that software starts inside the core do not enter this block and never reach its outputs.

The cause register tells the two kinds of reset apart. A rail fault sets the power bit. A power-on button press sets the button bit and leaves the power bit alone. A button XIR changes neither the system reset nor the cause register.

Top module: `rst_src_ctrl`

## Requirements
- R1: While any bit of `rail_good` is 0, `sys_por_n` is 0 from the next clock edge on, and cause bit 0 (power) is set.
- R2: While `cfg_done` is 0, `sys_por_n` is 0 from the next clock edge on.
- R3: `sys_por_n` rises exactly HOLD_CYCLES (default 256) clock edges after the last edge at which a reset condition or the block reset `rst` was present.
- R4: An accepted power-on button press asserts `sys_por_n` low, sets cause bit 1 (button), and does not set cause bit 0.
- R5: A button level is accepted only after it has held steady for DEB_LEN (default 16) consecutive sample ticks. A tick comes every TICK_DIV clocks. Shorter pulses have no effect.
- R6: When `sts_wr_en` is 1, each 1 in `sts_wr_data` clears the matching cause bit, and each 0 leaves that bit unchanged. Bit 0 is the power bit and bit 1 is the button bit, in both `sts_wr_data` and `status`.
- R7: When a set event and a clear write hit the same cause bit in the same cycle, the bit ends up set.
- R8: Each accepted XIR button press gives exactly one `xir_pulse` of one cycle. It changes neither `sys_por_n` nor `status`.
- R9: No `xir_pulse` is produced while a system reset is active.
- R10: While `rst` is 1, `sys_por_n` is 0, `xir_pulse` is 0 and `status` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| rail_good | input | NUM_RAILS | Per-rail good flag, 1 = within tolerance |
| cfg_done | input | 1 | Configuration complete |
| btn_por | input | 1 | Raw power-on button, active high |
| btn_xir | input | 1 | Raw XIR button, active high |
| sts_wr_en | input | 1 | Cause register write strobe |
| sts_wr_data | input | 2 | Write-one-to-clear mask |
| sys_por_n | output | 1 | Active-low system reset |
| xir_pulse | output | 1 | Single-cycle XIR request |
| status | output | 2 | Cause bits: [0] power, [1] button |

## Verification
The bench steps through all sixteen combinations of the three rail flags and the configuration flag. Each combination shows whether a single rail fault, several rail faults, or only missing configuration is enough to hold reset and to set the power cause. For every combination the release delay is measured edge by edge. Button pulses shorter than the debounce window are compared with long presses, which shows that only debounced presses act. XIR presses are given with the rails good and again during a fault, which shows that a pulse happens only when the system is out of reset. Clear writes are made with the source held active, with a zero mask, and with a one mask, which separates set priority from a plain clear.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

    localparam int CAUSE_W = 2;

    typedef struct packed {
        logic btn;
        logic pwr;
    } cause_t;

    typedef enum logic [1:0] {
        BTN_POR = 2'd0,
        BTN_XIR = 2'd1
    } btn_id_e;

    localparam int NUM_BTN = 2;

    function automatic logic rails_bad(input logic [7:0] good, input int n);
        logic bad;
        bad = 1'b0;
        for (int i = 0; i < n; i++) begin
            bad = bad | ~good[i];
        end
        return bad;
    endfunction

endpackage

// File: rtl/rsc_debounce.sv
module rsc_debounce #(
    parameter int DEB_LEN = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic raw,
    output logic press
);
    localparam int CW = (DEB_LEN > 1) ? $clog2(DEB_LEN) : 1;

    logic [1:0]    sync_q;
    logic          level_q;
    logic          level_d1;
    logic [CW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q   <= '0;
            level_q  <= 1'b0;
            level_d1 <= 1'b0;
            run_q    <= '0;
        end else begin
            sync_q   <= {sync_q[0], raw};
            level_d1 <= level_q;
            if (tick) begin
                if (sync_q[1] == level_q) begin
                    run_q <= '0;
                end else if (run_q == CW'(DEB_LEN - 1)) begin
                    level_q <= sync_q[1];
                    run_q   <= '0;
                end else begin
                    run_q <= run_q + 1'b1;
                end
            end
        end
    end

    assign press = level_q & ~level_d1;
endmodule

// File: rtl/rsc_hold_timer.sv
module rsc_hold_timer #(
    parameter int HOLD_CYCLES = 256
) (
    input  logic clk,
    input  logic rst,
    input  logic req,
    output logic released
);
    localparam int HW = $clog2(HOLD_CYCLES + 1);

    logic [HW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || req) begin
            cnt_q <= '0;
        end else if (cnt_q != HW'(HOLD_CYCLES)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign released = (cnt_q == HW'(HOLD_CYCLES));
endmodule

// File: rtl/rsc_cause_reg.sv
module rsc_cause_reg
    import rsc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  cause_t set_ev,
    input  logic   wr_en,
    input  cause_t wr_mask,
    output cause_t cause
);
    cause_t cause_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cause_q <= '0;
        end else begin
            for (int i = 0; i < CAUSE_W; i++) begin
                if (set_ev[i]) begin
                    cause_q[i] <= 1'b1;
                end else if (wr_en && wr_mask[i]) begin
                    cause_q[i] <= 1'b0;
                end
            end
        end
    end

    assign cause = cause_q;
endmodule

// File: rtl/rst_src_ctrl.sv
module rst_src_ctrl
    import rsc_pkg::*;
#(
    parameter int NUM_RAILS   = 3,
    parameter int DEB_LEN     = 16,
    parameter int HOLD_CYCLES = 256,
    parameter int TICK_DIV    = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_RAILS-1:0] rail_good,
    input  logic                 cfg_done,
    input  logic                 btn_por,
    input  logic                 btn_xir,
    input  logic                 sts_wr_en,
    input  logic [1:0]           sts_wr_data,
    output logic                 sys_por_n,
    output logic                 xir_pulse,
    output logic [1:0]           status
);
    localparam int TW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    logic [TW-1:0]      tick_cnt;
    logic               tick;
    logic [NUM_BTN-1:0] btn_raw;
    logic [NUM_BTN-1:0] btn_acc;
    logic               fault;
    logic               por_req;
    logic               released;
    logic               xir_q;
    cause_t             set_ev;
    cause_t             cause;

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_cnt <= '0;
            tick     <= 1'b0;
        end else if (tick_cnt == TW'(TICK_DIV - 1)) begin
            tick_cnt <= '0;
            tick     <= 1'b1;
        end else begin
            tick_cnt <= tick_cnt + 1'b1;
            tick     <= 1'b0;
        end
    end

    assign btn_raw[BTN_POR] = btn_por;
    assign btn_raw[BTN_XIR] = btn_xir;

    for (genvar g = 0; g < NUM_BTN; g++) begin : g_btn
        rsc_debounce #(.DEB_LEN(DEB_LEN)) u_deb (
            .clk   (clk),
            .rst   (rst),
            .tick  (tick),
            .raw   (btn_raw[g]),
            .press (btn_acc[g])
        );
    end

    assign fault   = rails_bad(8'(rail_good), NUM_RAILS);
    assign por_req = fault | ~cfg_done | btn_acc[BTN_POR];

    rsc_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .req      (por_req),
        .released (released)
    );

    assign set_ev.pwr = fault;
    assign set_ev.btn = btn_acc[BTN_POR];

    rsc_cause_reg u_cause (
        .clk     (clk),
        .rst     (rst),
        .set_ev  (set_ev),
        .wr_en   (sts_wr_en),
        .wr_mask (cause_t'(sts_wr_data)),
        .cause   (cause)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            xir_q <= 1'b0;
        end else begin
            xir_q <= btn_acc[BTN_XIR] & released & ~por_req;
        end
    end

    assign sys_por_n = released;
    assign xir_pulse = xir_q;
    assign status    = cause;
endmodule

// File: rtl/rst_src_ctrl_chk.sv
module rst_src_ctrl_chk #(
    parameter int NUM_RAILS = 3
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NUM_RAILS-1:0] rail_good,
    input logic                 cfg_done,
    input logic                 sts_wr_en,
    input logic [1:0]           sts_wr_data,
    input logic                 sys_por_n,
    input logic                 xir_pulse,
    input logic [1:0]           status
);
    assert_fault_holds_reset_R1: assert property (@(posedge clk) disable iff (rst)
        (rail_good != '1) |=> !sys_por_n);

    assert_fault_sets_pwr_R1: assert property (@(posedge clk) disable iff (rst)
        (rail_good != '1) |=> status[0]);

    assert_cfg_holds_reset_R2: assert property (@(posedge clk) disable iff (rst)
        !cfg_done |=> !sys_por_n);

    assert_release_needs_good_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(sys_por_n) |-> $past((rail_good == '1) && cfg_done));

    assert_btn_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (status[1] && !(sts_wr_en && sts_wr_data[1])) |=> status[1]);

    assert_xir_single_R8: assert property (@(posedge clk) disable iff (rst)
        xir_pulse |=> !xir_pulse);

    assert_xir_quiet_in_reset_R9: assert property (@(posedge clk) disable iff (rst)
        xir_pulse |-> sys_por_n);
endmodule

bind rst_src_ctrl rst_src_ctrl_chk #(.NUM_RAILS(NUM_RAILS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .rail_good   (rail_good),
    .cfg_done    (cfg_done),
    .sts_wr_en   (sts_wr_en),
    .sts_wr_data (sts_wr_data),
    .sys_por_n   (sys_por_n),
    .xir_pulse   (xir_pulse),
    .status      (status)
);

// File: tb/tb_rst_src_ctrl.sv
module tb_rst_src_ctrl;
    localparam int NR   = 3;
    localparam int DEB  = 4;
    localparam int HOLD = 8;
    localparam int TDIV = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NR-1:0] rail_good = '1;
    logic          cfg_done = 1'b1;
    logic          btn_por = 1'b0;
    logic          btn_xir = 1'b0;
    logic          sts_wr_en = 1'b0;
    logic [1:0]    sts_wr_data = '0;
    logic          sys_por_n;
    logic          xir_pulse;
    logic [1:0]    status;

    int n_chk = 0;
    int n_fail = 0;
    int xir_seen = 0;
    int por_low_seen = 0;

    always #5 clk = ~clk;

    rst_src_ctrl #(.NUM_RAILS(NR), .DEB_LEN(DEB), .HOLD_CYCLES(HOLD), .TICK_DIV(TDIV)) dut (
        .clk(clk), .rst(rst), .rail_good(rail_good), .cfg_done(cfg_done),
        .btn_por(btn_por), .btn_xir(btn_xir), .sts_wr_en(sts_wr_en),
        .sts_wr_data(sts_wr_data), .sys_por_n(sys_por_n),
        .xir_pulse(xir_pulse), .status(status)
    );

    always @(negedge clk) begin
        if (xir_pulse) xir_seen <= xir_seen + 1;
        if (!sys_por_n) por_low_seen <= por_low_seen + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic measure_release(input string req);
        int n;
        n = 0;
        while (!sys_por_n && n < 10 * HOLD) begin
            @(negedge clk);
            n++;
        end
        chk(n == HOLD, req, n, HOLD);
    endtask

    task automatic wr_status(input logic [1:0] m);
        sts_wr_en = 1'b1;
        sts_wr_data = m;
        @(negedge clk);
        sts_wr_en = 1'b0;
        sts_wr_data = '0;
    endtask

    task automatic press(input bit which_xir, input int len);
        if (which_xir) btn_xir = 1'b1; else btn_por = 1'b1;
        cyc(len);
        btn_xir = 1'b0;
        btn_por = 1'b0;
        cyc(40);
    endtask

    initial begin
        #(200000 * 10);
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        int x0, p0;
        @(negedge clk);
        cyc(4);
        // R10 reset state
        chk(sys_por_n == 1'b0, "R10 sys_por_n", sys_por_n, 0);
        chk(xir_pulse == 1'b0, "R10 xir_pulse", xir_pulse, 0);
        chk(status == 2'b00, "R10 status", status, 0);
        rst = 1'b0;
        measure_release("R3 after block reset");

        // R1/R2/R3 sweep over every rail and config combination
        for (int c = 0; c < 16; c++) begin
            bit any_bad, asserted;
            rail_good = c[2:0];
            cfg_done = c[3];
            any_bad = (c[2:0] != 3'b111);
            asserted = any_bad || !c[3];
            cyc(3);
            chk(sys_por_n == !asserted, any_bad ? "R1 reset level" : "R2 reset level",
                sys_por_n, !asserted);
            chk(status[0] == any_bad, "R1 power cause", status[0], any_bad);
            rail_good = '1;
            cfg_done = 1'b1;
            if (asserted) measure_release("R3 release delay");
            wr_status(2'b11);
            chk(status == 2'b00, "R6 clear all", status, 0);
        end

        // R7 set wins over clear
        rail_good = 3'b110;
        cyc(2);
        wr_status(2'b01);
        chk(status[0] == 1'b1, "R7 set priority", status[0], 1);
        rail_good = '1;
        measure_release("R3 after rail restore");
        wr_status(2'b01);
        chk(status == 2'b00, "R6 clear power", status, 0);

        // R5 short glitch ignored
        p0 = por_low_seen;
        press(1'b0, 3);
        chk(por_low_seen == p0, "R5 glitch reset", por_low_seen - p0, 0);
        chk(status == 2'b00, "R5 glitch status", status, 0);

        // R4 button power-on reset
        p0 = por_low_seen;
        press(1'b0, 60);
        chk(por_low_seen - p0 == HOLD, "R4 button reset length", por_low_seen - p0, HOLD);
        chk(status == 2'b10, "R4 cause bits", status, 2);
        wr_status(2'b01);
        chk(status == 2'b10, "R6 zero mask keeps", status, 2);
        wr_status(2'b10);
        chk(status == 2'b00, "R6 clear button", status, 0);

        // R8 XIR with rails good
        x0 = xir_seen;
        p0 = por_low_seen;
        press(1'b1, 60);
        chk(xir_seen - x0 == 1, "R8 pulse count", xir_seen - x0, 1);
        chk(por_low_seen == p0, "R8 no reset", por_low_seen - p0, 0);
        chk(status == 2'b00, "R8 no cause", status, 0);
        press(1'b1, 60);
        press(1'b1, 60);
        chk(xir_seen - x0 == 3, "R8 repeated presses", xir_seen - x0, 3);

        // R5 short XIR glitch
        x0 = xir_seen;
        press(1'b1, 3);
        chk(xir_seen == x0, "R5 xir glitch", xir_seen - x0, 0);

        // R9 XIR during fault
        rail_good = 3'b011;
        x0 = xir_seen;
        press(1'b1, 60);
        chk(xir_seen == x0, "R9 suppressed", xir_seen - x0, 0);
        rail_good = '1;
        measure_release("R3 after suppression test");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule